// File: doc/BRIEF.md
# Processor Input Pin Conditioner

This block sits between the board-level control pins of a processor core and its exception logic. Six pins arrive on one bus: hard reset, soft reset, checkstop, machine check, system management and external interrupt. The block holds the last level seen on every pin and reacts only when a pin actually changes. From those changes it keeps a four-bit pending-exception map, a halt flag and a synchronous core reset.

The exception side is a handshake. `pend_any_o` acts as the valid signal and `take_i` as the core's ready. When both are high at a clock edge, one exception is taken. The highest-priority pending bit is chosen, and its code appears on `taken_code_o` with `taken_valid_o` high for exactly one clock. The take report cannot be stalled. The core must accept it in that cycle, and holding `take_i` low is the only way to apply back-pressure. Pins are sampled once per clock, and every output is registered, so each effect shows up one edge after its cause.

Top module: `pin_cond`

## Requirements
- R1: While `rst_n` is low and after it is released with all pins low, `pend_o`, `pend_any_o`, `halt_o`, `core_rst_o`, `taken_valid_o` and `taken_code_o` are all zero, and every stored pin level is zero.
- R2: A pin held at a constant level has no further effect: a pending bit cleared by a take is not set again until that pin changes.
- R3: Pin index 5 (external interrupt) is level-sensitive, and pending bit 2 equals its level one clock later.
- R4: Pin index 4 (system management) is level-sensitive, and pending bit 3 equals its level one clock later.
- R5: Pin index 1 (soft reset) drives pending bit 0 on each change: a rise sets the bit and a fall clears it, one clock later.
- R6: Pin index 3 (machine check) sets pending bit 1 only on a 1-to-0 change. A 0-to-1 change neither sets nor clears that bit.
- R7: `halt_o` follows pin index 2 (checkstop) one clock later.
- R8: `core_rst_o` follows pin index 0 (hard reset) one clock later.
- R9: When `take_i` and `pend_any_o` are both high at an edge, `taken_valid_o` is high for the next clock only. `taken_code_o` then holds the index of the lowest-numbered pending bit, so the priority is 0 (reset), then 1 (machine check), then 2 (external), then 3 (system management). With nothing pending, `take_i` produces no take.
- R10: A take clears pending bit 0 or bit 1 when that bit is the one taken. Bits 2 and 3 are never cleared by a take.
- R11: `pend_any_o` is high exactly when some bit of `pend_o` is high.
- R12: If a pin change that sets a pending bit arrives in the same clock as the take that clears that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 6 | Pin levels: 0 hard reset, 1 soft reset, 2 checkstop, 3 machine check, 4 system management, 5 external interrupt |
| take_i | input | 1 | Core ready to take one exception |
| pend_o | output | 4 | Pending map: 0 reset, 1 machine check, 2 external, 3 system management |
| pend_any_o | output | 1 | Some exception is pending (handshake valid) |
| halt_o | output | 1 | Core halted by checkstop |
| core_rst_o | output | 1 | Synchronous core reset from hard reset pin |
| taken_valid_o | output | 1 | One-clock pulse reporting a take |
| taken_code_o | output | 2 | Pending-bit index of the taken exception, zero otherwise |

## Verification
The assertions assume that pins and `take_i` are already synchronous to `clk` and stable around each rising edge. They also assume that one full clock passes after reset release before the pin-follow checks apply, because the stored levels only become meaningful after the first sample. The stimulus changes pins and `take_i` only on falling edges and checks outputs at the next falling edge. The clear-versus-set collision on the machine check bit is exercised on purpose, with the new falling pin edge and the take issued in the same cycle.

// File: rtl/pinc_pkg.sv
package pinc_pkg;
  localparam int NPIN      = 6;
  localparam int PIN_HRST  = 0;
  localparam int PIN_SRST  = 1;
  localparam int PIN_CKSTP = 2;
  localparam int PIN_MCHK  = 3;
  localparam int PIN_SMI   = 4;
  localparam int PIN_EXT   = 5;

  localparam int NPEND     = 4;
  localparam int PEND_RST  = 0;
  localparam int PEND_MCHK = 1;
  localparam int PEND_EXT  = 2;
  localparam int PEND_SMI  = 3;
  localparam int CODE_W    = $clog2(NPEND);
endpackage

// File: rtl/pinc_level_track.sv
module pinc_level_track
  import pinc_pkg::*;
#(
  parameter int W = NPIN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] lvl_q;

  for (genvar g = 0; g < W; g++) begin : g_pin
    assign chg_o[g] = pin_i[g] ^ lvl_q[g];
    always_ff @(posedge clk) begin
      if (!rst_n)        lvl_q[g] <= 1'b0;
      else if (chg_o[g]) lvl_q[g] <= pin_i[g];
    end
  end
endmodule

// File: rtl/pinc_pend_reg.sv
module pinc_pend_reg
  import pinc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIN-1:0]  pin_i,
  input  logic [NPIN-1:0]  chg_i,
  input  logic             clr_rst_i,
  input  logic             clr_mchk_i,
  output logic [NPEND-1:0] pend_o,
  output logic             halt_o,
  output logic             core_rst_o
);
  logic mchk_fall;
  assign mchk_fall = chg_i[PIN_MCHK] & ~pin_i[PIN_MCHK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_o     <= '0;
      halt_o     <= 1'b0;
      core_rst_o <= 1'b0;
    end else begin
      // soft reset: level-driven on change, pin change beats take clear
      if (chg_i[PIN_SRST])  pend_o[PEND_RST] <= pin_i[PIN_SRST];
      else if (clr_rst_i)   pend_o[PEND_RST] <= 1'b0;
      // machine check: falling edge only
      if (mchk_fall)        pend_o[PEND_MCHK] <= 1'b1;
      else if (clr_mchk_i)  pend_o[PEND_MCHK] <= 1'b0;
      if (chg_i[PIN_EXT])   pend_o[PEND_EXT] <= pin_i[PIN_EXT];
      if (chg_i[PIN_SMI])   pend_o[PEND_SMI] <= pin_i[PIN_SMI];
      if (chg_i[PIN_CKSTP]) halt_o     <= pin_i[PIN_CKSTP];
      if (chg_i[PIN_HRST])  core_rst_o <= pin_i[PIN_HRST];
    end
  end
endmodule

// File: rtl/pinc_take_arb.sv
module pinc_take_arb
  import pinc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPEND-1:0]  pend_i,
  input  logic              take_i,
  output logic              clr_rst_o,
  output logic              clr_mchk_o,
  output logic              taken_valid_o,
  output logic [CODE_W-1:0] taken_code_o
);
  logic              hit;
  logic [CODE_W-1:0] code;
  logic              fire;

  always_comb begin
    hit  = 1'b0;
    code = '0;
    for (int i = 0; i < NPEND; i++) begin
      if (!hit && pend_i[i]) begin
        hit  = 1'b1;
        code = CODE_W'(i);
      end
    end
  end

  assign fire       = take_i & hit;
  assign clr_rst_o  = fire && (code == CODE_W'(PEND_RST));
  assign clr_mchk_o = fire && (code == CODE_W'(PEND_MCHK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_valid_o <= 1'b0;
      taken_code_o  <= '0;
    end else begin
      taken_valid_o <= fire;
      taken_code_o  <= fire ? code : '0;
    end
  end
endmodule

// File: rtl/pin_cond.sv
module pin_cond
  import pinc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              take_i,
  output logic [NPEND-1:0]  pend_o,
  output logic              pend_any_o,
  output logic              halt_o,
  output logic              core_rst_o,
  output logic              taken_valid_o,
  output logic [CODE_W-1:0] taken_code_o
);
  logic [NPIN-1:0] chg;
  logic            clr_rst, clr_mchk;

  pinc_level_track #(.W(NPIN)) u_track (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .chg_o(chg)
  );

  pinc_pend_reg u_pend (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .chg_i(chg),
    .clr_rst_i(clr_rst), .clr_mchk_i(clr_mchk),
    .pend_o(pend_o), .halt_o(halt_o), .core_rst_o(core_rst_o)
  );

  pinc_take_arb u_arb (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_o), .take_i(take_i),
    .clr_rst_o(clr_rst), .clr_mchk_o(clr_mchk),
    .taken_valid_o(taken_valid_o), .taken_code_o(taken_code_o)
  );

  assign pend_any_o = |pend_o;
endmodule

// File: rtl/pin_cond_chk.sv
module pin_cond_chk
  import pinc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NPIN-1:0]   pin_i,
  input logic              take_i,
  input logic [NPEND-1:0]  pend_o,
  input logic              pend_any_o,
  input logic              halt_o,
  input logic              core_rst_o,
  input logic              taken_valid_o,
  input logic [CODE_W-1:0] taken_code_o
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R7
  halt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> halt_o == $past(pin_i[PIN_CKSTP]));

  // R8
  hrst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> core_rst_o == $past(pin_i[PIN_HRST]));

  // R3
  ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> pend_o[PEND_EXT] == $past(pin_i[PIN_EXT]));

  // R6
  mchk_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(pend_o[PEND_MCHK])) |-> !$past(pin_i[PIN_MCHK]));

  // R9
  take_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && taken_valid_o) |-> ($past(take_i) && $past(pend_any_o)));

  // R9
  take_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && taken_valid_o && taken_code_o == CODE_W'(PEND_EXT))
      |-> !$past(pend_o[PEND_RST]) && !$past(pend_o[PEND_MCHK]));

  // R11
  any_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any_o == ($countones(pend_o) != 0));
endmodule

bind pin_cond pin_cond_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .take_i(take_i),
  .pend_o(pend_o), .pend_any_o(pend_any_o), .halt_o(halt_o),
  .core_rst_o(core_rst_o), .taken_valid_o(taken_valid_o),
  .taken_code_o(taken_code_o)
);

// File: tb/pin_cond_tb.sv
module pin_cond_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] pin;
  logic       take;
  logic [3:0] pend;
  logic       pend_any, halt, core_rst, tv;
  logic [1:0] tcode;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_cond u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .take_i(take),
    .pend_o(pend), .pend_any_o(pend_any), .halt_o(halt),
    .core_rst_o(core_rst), .taken_valid_o(tv), .taken_code_o(tcode)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pend_is(input string req, input logic [3:0] e);
    chk(req, {4'b0, pend}, {4'b0, e});
    chk({req, " any"}, {7'b0, pend_any}, {7'b0, |e});
  endtask

  // driver: request one take, expected code goes to the scoreboard
  task automatic take_one(input logic [1:0] code);
    exp_q.push_back(code);
    take = 1'b1;
    step();
    take = 1'b0;
  endtask

  // monitor: compares every reported take with the scoreboard
  always @(negedge clk) begin
    if (rst_n && tv) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9: actual=take code %0d expected=no take", tcode);
      end else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        if (tcode !== e) begin
          errors++;
          $display("FAIL R9: actual=%0d expected=%0d", tcode, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin = '0; take = 1'b0;
    repeat (3) step();
    // R1 during reset
    pend_is("R1", 4'b0000);
    chk("R1 halt", {7'b0, halt}, 8'd0);
    chk("R1 core_rst", {7'b0, core_rst}, 8'd0);
    chk("R1 tv", {7'b0, tv}, 8'd0);
    rst_n = 1'b1;
    step(); step();
    pend_is("R1", 4'b0000);
    chk("R1 code", {6'b0, tcode}, 8'd0);

    // R3 external follows level
    pin[5] = 1'b1; step(); pend_is("R3", 4'b0100);
    pin[5] = 1'b0; step(); pend_is("R3", 4'b0000);
    // R4 system management follows level
    pin[4] = 1'b1; step(); pend_is("R4", 4'b1000);
    // R6 rise ignored, fall sets
    pin[3] = 1'b1; step(); pend_is("R6 rise", 4'b1000);
    pin[3] = 1'b0; step(); pend_is("R6 fall", 4'b1010);
    // R9 machine check beats smi; R10 clears it
    take_one(2'd1); pend_is("R10 mchk", 4'b1000);
    // R2 held-low pin has no further effect
    repeat (3) step();
    pend_is("R2 mchk", 4'b1000);
    chk("R9 single pulse", {7'b0, tv}, 8'd0);
    // R9 ext beats smi, R10 ext not cleared
    pin[5] = 1'b1; step(); pend_is("R3", 4'b1100);
    take_one(2'd2); pend_is("R10 ext", 4'b1100);
    // R5 soft reset; R9 reset first; R10 clear
    pin[1] = 1'b1; step(); pend_is("R5 rise", 4'b1101);
    take_one(2'd0); pend_is("R10 rst", 4'b1100);
    repeat (2) step(); pend_is("R2 srst", 4'b1100);
    pin[1] = 1'b0; step(); pend_is("R5 fall", 4'b1100);
    pin[1] = 1'b1; step(); pend_is("R5 rise", 4'b1101);
    pin[1] = 1'b0; step(); pend_is("R5 level", 4'b1100);
    // R12 new fall in same cycle as take of machine check
    pin[3] = 1'b1; step();
    pin[3] = 1'b0; step(); pend_is("R6", 4'b1110);
    pin[3] = 1'b1; step(); pend_is("R6 rise", 4'b1110);
    pin[3] = 1'b0;
    take_one(2'd1); pend_is("R12", 4'b1110);
    // R4 smi drop, ext drop, then drain
    pin[4] = 1'b0; pin[5] = 1'b0; step(); pend_is("R4", 4'b0010);
    take_one(2'd1); pend_is("R10", 4'b0000);
    // R9 take with nothing pending: monitor flags any report
    take = 1'b1; step(); take = 1'b0; step();
    chk("R9 empty", {7'b0, tv}, 8'd0);
    // R9 smi lowest, taken alone
    pin[4] = 1'b1; step();
    take_one(2'd3); pend_is("R10 smi", 4'b1000);
    // R7 checkstop
    pin[2] = 1'b1; step(); chk("R7 on", {7'b0, halt}, 8'd1);
    pin[2] = 1'b0; step(); chk("R7 off", {7'b0, halt}, 8'd0);
    // R8 hard reset
    pin[0] = 1'b1; step(); chk("R8 on", {7'b0, core_rst}, 8'd1);
    pin[0] = 1'b0; step(); chk("R8 off", {7'b0, core_rst}, 8'd0);
    step();
    chk("R9 scoreboard drained", 8'(exp_q.size()), 8'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule